// File: doc/BRIEF.md
# Hybrid Circuit/Packet Mesh Router

This block is one five-port mesh router: a local port that injects and ejects flits, plus links to the north, south, east and west. Every link carries two kinds of flit, told apart by a one-bit tag that travels with each flit. A circuit flit arrives on an input whose per-input circuit entry names a fixed output. It skips buffering and allocation and is registered straight onto that output, so it spends one router stage. A packet flit is written into its input queue and then competes in a round-robin switch allocator. After that it crosses the crossbar, so it spends three stages in total.

Circuit entries are written through a small configuration port, which stands in for the separate setup network that delivers them. Circuit traffic always has first claim on an output link. A packet flit that already holds a grant sends in any cycle that has no circuit flit for that output, so packets use the idle cycles of circuit links. When a queue is full, the router drops a per-input ready bit towards the upstream neighbour.

Top module: `hcs_router`

## Requirements
- R1: After a synchronous reset, all outputs are invalid and untagged, and every input reports ready.
- R2: A flit tagged circuit (tag 1), arriving on an input whose circuit entry is enabled, appears on the entry's output one clock edge later. It keeps tag 1 and its data is unchanged.
- R3: A flit tagged packet (tag 0) appears three clock edges after arrival, with tag 0 and unchanged data. It leaves on the output whose number is in the top three data bits (0 local, 1 north, 2 south, 3 east, 4 west).
- R4: A configuration write to an input's circuit entry (enable or clear) applies to flits arriving in the following cycle. A circuit-tagged flit on an input with no enabled entry is buffered and routed as a packet by its destination field, and leaves tagged 0.
- R5: An output carries a circuit flit whenever one targets it. A granted packet flit waits while that holds, and leaves in the first cycle with no circuit flit for that output.
- R6: Packet flits that contend for one output are granted in round-robin order. The search starts one input past the last input granted for that output, and the pointer starts at input 0 after reset.
- R7: When two circuit flits target the same output in one cycle, the lower-numbered input goes through as a circuit flit. The other flit is buffered and later leaves as a packet by its destination field.
- R8: An input queue holds DEPTH flits. With DEPTH flits queued, that input's ready is low. Flits from one input leave in arrival order, and none is lost or duplicated.
- R9: Packet flits from different inputs to different outputs cross the switch in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 5 | Flit present on each input link |
| in_circ | input | 5 | Tag per input: 1 circuit, 0 packet |
| in_data | input | 5*DATA_W | Flit data per input; the top 3 bits are the packet destination |
| in_ready | output | 5 | Input queue has room (credit to upstream) |
| cfg_we | input | 1 | Write one circuit entry |
| cfg_port | input | 3 | Input whose entry is written |
| cfg_out | input | 3 | Output the circuit maps to |
| cfg_set | input | 1 | 1 enables the entry, 0 clears it |
| out_valid | output | 5 | Registered flit present on each output link |
| out_circ | output | 5 | Registered tag per output |
| out_data | output | 5*DATA_W | Registered flit data per output |

## Verification
The bench sweeps all 25 input/output pairs twice. The circuit pass must show a one-edge latency with tag 1, and the packet pass must show three edges with tag 0, which separates the bypass from the buffered path. Other patterns target the corner cases:
- A circuit stream laid over a granted packet, and two circuit flits aimed at one output in the same cycle, separate priority and stealing from loss.
- A lone contender followed by two- and four-way contention shows that the allocator really rotates and is not fixed-priority.
- A queue filled behind a blocked output exposes the ready bit and the drain order.
- A full permutation checks that the crossbar runs in parallel.

// File: rtl/hcs_pkg.sv
package hcs_pkg;
  // five router ports: local, north, south, east, west
  localparam int NPORT = 5;
  localparam int PW    = $clog2(NPORT);
endpackage

// File: rtl/hcs_fifo.sv
module hcs_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         empty,
  output logic         full
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0]   cnt;

  // storage without reset so it maps onto distributed RAM
  always_ff @(posedge clk) begin
    if (push) mem[wp] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= wp + AW'(1);
      if (pop)  rp <= rp + AW'(1);
      cnt <= cnt + {{AW{1'b0}}, push} - {{AW{1'b0}}, pop};
    end
  end

  assign head  = mem[rp];
  assign empty = (cnt == '0);
  assign full  = (cnt == (AW+1)'(DEPTH));

  // R8: the upstream side never writes a full queue
  a_r8_no_push_full: assert property (@(posedge clk) disable iff (rst) push |-> !full);
  // R8: the allocator never removes from an empty queue
  a_r8_no_pop_empty: assert property (@(posedge clk) disable iff (rst) pop |-> !empty);
endmodule

// File: rtl/hcs_circuit_table.sv
module hcs_circuit_table
  import hcs_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [PW-1:0]    cfg_port,
  input  logic [PW-1:0]    cfg_out,
  input  logic             cfg_set,
  input  logic [NPORT-1:0] fl_valid,
  input  logic [NPORT-1:0] fl_circ,
  output logic [NPORT-1:0] cwin,
  output logic [NPORT-1:0] claim,
  output logic [PW-1:0]    claim_src [NPORT]
);
  logic [NPORT-1:0] tbl_v;
  logic [PW-1:0]    tbl_o [NPORT];

  always_ff @(posedge clk) begin
    if (rst) begin
      tbl_v <= '0;
      for (int i = 0; i < NPORT; i++) tbl_o[i] <= '0;
    end else if (cfg_we && cfg_port < PW'(NPORT) && cfg_out < PW'(NPORT)) begin
      tbl_v[cfg_port] <= cfg_set;
      tbl_o[cfg_port] <= cfg_out;
    end
  end

  // lower-numbered inputs claim first; losers fall back to their queue
  always_comb begin
    claim = '0;
    cwin  = '0;
    for (int o = 0; o < NPORT; o++) claim_src[o] = '0;
    for (int i = 0; i < NPORT; i++) begin
      if (fl_valid[i] && fl_circ[i] && tbl_v[i] && !claim[tbl_o[i]]) begin
        claim[tbl_o[i]]     = 1'b1;
        claim_src[tbl_o[i]] = PW'(i);
        cwin[i]             = 1'b1;
      end
    end
  end
endmodule

// File: rtl/hcs_sw_alloc.sv
module hcs_sw_alloc
  import hcs_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [NPORT-1:0] head_v,
  input  logic [PW-1:0]    head_dst [NPORT],
  input  logic [NPORT-1:0] fire,
  output logic [NPORT-1:0] gnt_v,
  output logic [PW-1:0]    gnt_in [NPORT],
  output logic [NPORT-1:0] pop
);
  logic [PW-1:0]    rr [NPORT];
  logic [NPORT-1:0] held;
  logic [NPORT-1:0] req [NPORT];
  logic [NPORT-1:0] pick_v;
  logic [PW-1:0]    pick [NPORT];

  // inputs that already own an output, and those whose head crosses now
  always_comb begin
    held = '0;
    pop  = '0;
    for (int o = 0; o < NPORT; o++) begin
      if (gnt_v[o]) begin
        held[gnt_in[o]] = 1'b1;
        if (fire[o]) pop[gnt_in[o]] = 1'b1;
      end
    end
  end

  // input stage: each queue head requests exactly one output
  always_comb begin
    for (int o = 0; o < NPORT; o++)
      for (int i = 0; i < NPORT; i++)
        req[o][i] = head_v[i] && !held[i] && (head_dst[i] == PW'(o));
  end

  // output stage: rotating-priority search per output
  always_comb begin
    int idx;
    for (int o = 0; o < NPORT; o++) begin
      pick_v[o] = 1'b0;
      pick[o]   = '0;
      for (int k = 0; k < NPORT; k++) begin
        idx = int'(rr[o]) + k;
        if (idx >= NPORT) idx = idx - NPORT;
        if (!pick_v[o] && req[o][PW'(idx)]) begin
          pick_v[o] = 1'b1;
          pick[o]   = PW'(idx);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gnt_v <= '0;
      for (int o = 0; o < NPORT; o++) begin
        gnt_in[o] <= '0;
        rr[o]     <= '0;
      end
    end else begin
      for (int o = 0; o < NPORT; o++) begin
        if ((!gnt_v[o] || fire[o]) && pick_v[o]) begin
          gnt_v[o]  <= 1'b1;
          gnt_in[o] <= pick[o];
          rr[o]     <= (pick[o] == PW'(NPORT-1)) ? '0 : pick[o] + PW'(1);
        end else if (fire[o]) begin
          gnt_v[o] <= 1'b0;
        end
      end
    end
  end

  for (genvar o = 0; o < NPORT; o++) begin : g_out_chk
    // R5: a grant blocked by circuit traffic is kept, for the same input
    a_r5_grant_kept: assert property (@(posedge clk) disable iff (rst)
      gnt_v[o] && !fire[o] |=> gnt_v[o] && $stable(gnt_in[o]));
    // R9: the crossbar only moves a packet flit that holds a grant
    a_r9_fire_needs_grant: assert property (@(posedge clk) disable iff (rst)
      fire[o] |-> gnt_v[o]);
  end

  for (genvar i = 0; i < NPORT; i++) begin : g_in_chk
    logic [NPORT-1:0] gm;
    always_comb
      for (int o = 0; o < NPORT; o++) gm[o] = gnt_v[o] && (gnt_in[o] == PW'(i));
    // R8: one input never owns two outputs, so nothing is duplicated
    a_r8_single_grant: assert property (@(posedge clk) disable iff (rst) $onehot0(gm));
  end
endmodule

// File: rtl/hcs_router.sv
module hcs_router
  import hcs_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NPORT-1:0]        in_valid,
  input  logic [NPORT-1:0]        in_circ,
  input  logic [NPORT*DATA_W-1:0] in_data,
  output logic [NPORT-1:0]        in_ready,
  input  logic                    cfg_we,
  input  logic [PW-1:0]           cfg_port,
  input  logic [PW-1:0]           cfg_out,
  input  logic                    cfg_set,
  output logic [NPORT-1:0]        out_valid,
  output logic [NPORT-1:0]        out_circ,
  output logic [NPORT*DATA_W-1:0] out_data
);
  logic [DATA_W-1:0] in_word  [NPORT];
  logic [DATA_W-1:0] head_q   [NPORT];
  logic [DATA_W-1:0] out_word [NPORT];
  logic [NPORT-1:0]  cwin, claim, push, empty, full, head_v, gnt_v, fire, pop;
  logic [PW-1:0]     claim_src [NPORT];
  logic [PW-1:0]     head_dst  [NPORT];
  logic [PW-1:0]     gnt_in    [NPORT];

  hcs_circuit_table u_table (
    .clk       (clk),
    .rst       (rst),
    .cfg_we    (cfg_we),
    .cfg_port  (cfg_port),
    .cfg_out   (cfg_out),
    .cfg_set   (cfg_set),
    .fl_valid  (in_valid),
    .fl_circ   (in_circ),
    .cwin      (cwin),
    .claim     (claim),
    .claim_src (claim_src)
  );

  hcs_sw_alloc u_alloc (
    .clk      (clk),
    .rst      (rst),
    .head_v   (head_v),
    .head_dst (head_dst),
    .fire     (fire),
    .gnt_v    (gnt_v),
    .gnt_in   (gnt_in),
    .pop      (pop)
  );

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    assign in_word[p] = in_data[p*DATA_W +: DATA_W];
    // everything that is not a winning circuit flit is buffered
    assign push[p]    = in_valid[p] && !cwin[p];

    hcs_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_q (
      .clk   (clk),
      .rst   (rst),
      .push  (push[p]),
      .wdata (in_word[p]),
      .pop   (pop[p]),
      .head  (head_q[p]),
      .empty (empty[p]),
      .full  (full[p])
    );

    assign in_ready[p] = !full[p];
    assign head_v[p]   = !empty[p];
    assign head_dst[p] = head_q[p][DATA_W-1 -: PW];
    // packet flits take the link only when no circuit flit wants it
    assign fire[p]     = gnt_v[p] && !claim[p];
    assign out_data[p*DATA_W +: DATA_W] = out_word[p];
  end

  // crossbar and output registers (switch traversal stage)
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= '0;
      out_circ  <= '0;
      for (int p = 0; p < NPORT; p++) out_word[p] <= '0;
    end else begin
      for (int p = 0; p < NPORT; p++) begin
        if (claim[p])     out_word[p] <= in_word[claim_src[p]];
        else if (fire[p]) out_word[p] <= head_q[gnt_in[p]];
        out_valid[p] <= claim[p] || fire[p];
        out_circ[p]  <= claim[p];
      end
    end
  end

  for (genvar p = 0; p < NPORT; p++) begin : g_chk
    // R5: a circuit claim always reaches the link on the next edge, tagged
    a_r5_circuit_first: assert property (@(posedge clk) disable iff (rst)
      claim[p] |=> out_valid[p] && out_circ[p]);
    // R3: a packet that crosses is tagged as a packet
    a_r3_packet_tagged: assert property (@(posedge clk) disable iff (rst)
      fire[p] |=> out_valid[p] && !out_circ[p]);
    // R8: upstream honours the credit
    a_r8_ready_honoured: assert property (@(posedge clk) disable iff (rst)
      push[p] |-> in_ready[p]);
  end
endmodule

// File: tb/test_hcs_router.sv
module test_hcs_router;
  import hcs_pkg::*;
  localparam int DW    = 8;
  localparam int DEPTH = 4;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst;
  logic [NPORT-1:0]    in_valid, in_circ, in_ready, out_valid, out_circ;
  logic [NPORT*DW-1:0] in_data, out_data;
  logic                cfg_we, cfg_set;
  logic [PW-1:0]       cfg_port, cfg_out;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  hcs_router #(.DATA_W(DW), .DEPTH(DEPTH)) i_hcs_router (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_circ(in_circ), .in_data(in_data),
    .in_ready(in_ready), .cfg_we(cfg_we), .cfg_port(cfg_port), .cfg_out(cfg_out),
    .cfg_set(cfg_set), .out_valid(out_valid), .out_circ(out_circ), .out_data(out_data)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] od(input int o);
    return out_data[o*DW +: DW];
  endfunction

  function automatic logic [DW-1:0] mk(input int dst, input int pay);
    return {PW'(dst), (DW-PW)'(pay)};
  endfunction

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic idle();
    in_valid = '0;
    in_circ  = '0;
    in_data  = '0;
  endtask

  task automatic put(input int p, input bit c, input logic [DW-1:0] d);
    in_valid[p] = 1'b1;
    in_circ[p]  = c;
    in_data[p*DW +: DW] = d;
  endtask

  task automatic cfg(input int p, input int o, input bit s);
    cfg_we = 1'b1; cfg_port = PW'(p); cfg_out = PW'(o); cfg_set = s;
    tick();
    cfg_we = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1; idle(); cfg_we = 1'b0; cfg_port = '0; cfg_out = '0; cfg_set = 1'b0;
    repeat (3) tick();
    rst = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL all requirements: watchdog actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1
    chk("R1 out_valid", 32'(out_valid), 0);
    chk("R1 out_circ", 32'(out_circ), 0);
    chk("R1 in_ready", 32'(in_ready), 32'h1f);

    // R2 and R4: every pair as a circuit, entry written the cycle before use
    for (int i = 0; i < NPORT; i++)
      for (int o = 0; o < NPORT; o++) begin
        cfg(i, o, 1'b1);
        put(i, 1'b1, mk(0, i*5+o));
        tick(); idle();
        chk("R2 R4 circuit valid", 32'(out_valid), 1 << o);
        chk("R2 circuit tag", 32'(out_circ), 1 << o);
        chk("R2 circuit data", 32'(od(o)), 32'(mk(0, i*5+o)));
        cfg(i, o, 1'b0);
        chk("R2 no extra flit", 32'(out_valid), 0);
      end

    // R3: every pair as a packet, three edges
    for (int i = 0; i < NPORT; i++)
      for (int o = 0; o < NPORT; o++) begin
        put(i, 1'b0, mk(o, i*5+o+1));
        tick(); idle();
        chk("R3 not after one edge", 32'(out_valid), 0);
        tick();
        chk("R3 not after two edges", 32'(out_valid), 0);
        tick();
        chk("R3 packet valid", 32'(out_valid), 1 << o);
        chk("R3 packet tag", 32'(out_circ), 0);
        chk("R3 packet data", 32'(od(o)), 32'(mk(o, i*5+o+1)));
        tick();
      end

    // R4: cleared entry makes a circuit-tagged flit follow its destination field
    cfg(2, 1, 1'b1);
    cfg(2, 1, 1'b0);
    put(2, 1'b1, mk(3, 9));
    tick(); idle();
    chk("R4 no bypass", 32'(out_valid), 0);
    tick(); tick();
    chk("R4 fallback valid", 32'(out_valid), 1 << 3);
    chk("R4 fallback tag", 32'(out_circ), 0);
    chk("R4 fallback data", 32'(od(3)), 32'(mk(3, 9)));
    tick();

    // R5: circuit stream on west holds a granted packet, which then steals the link
    cfg(1, 4, 1'b1);
    put(0, 1'b0, mk(4, 21));
    for (int k = 0; k < 5; k++) begin
      put(1, 1'b1, mk(0, k+1));
      tick();
      in_valid[0] = 1'b0;
      chk("R5 circuit first valid", 32'(out_valid[4]), 1);
      chk("R5 circuit first tag", 32'(out_circ[4]), 1);
      chk("R5 circuit first data", 32'(od(4)), 32'(mk(0, k+1)));
    end
    idle();
    tick();
    chk("R5 steal valid", 32'(out_valid), 1 << 4);
    chk("R5 steal tag", 32'(out_circ), 0);
    chk("R5 steal data", 32'(od(4)), 32'(mk(4, 21)));
    cfg(1, 4, 1'b0);

    // R9: a full permutation crosses in parallel
    for (int i = 0; i < NPORT; i++) put(i, 1'b0, mk((i+1) % NPORT, 10+i));
    tick(); idle(); tick(); tick();
    chk("R9 all outputs valid", 32'(out_valid), 32'h1f);
    chk("R9 all tagged packet", 32'(out_circ), 0);
    for (int i = 0; i < NPORT; i++)
      chk("R9 permutation data", 32'(od((i+1) % NPORT)), 32'(mk((i+1) % NPORT, 10+i)));
    tick();

    // R6: round robin on the local output from a fresh reset
    do_reset();
    put(3, 1'b0, mk(0, 3));
    tick(); idle();
    repeat (4) tick();
    put(1, 1'b0, mk(0, 11));
    put(4, 1'b0, mk(0, 14));
    tick(); idle(); tick(); tick();
    chk("R6 pointer past input 3 picks 4", 32'(od(0)), 32'(mk(0, 14)));
    chk("R6 first valid", 32'(out_valid[0]), 1);
    tick();
    chk("R6 then input 1", 32'(od(0)), 32'(mk(0, 11)));
    chk("R6 second valid", 32'(out_valid[0]), 1);
    tick();
    for (int i = 1; i < NPORT; i++) put(i, 1'b0, mk(0, 20+i));
    tick(); idle(); tick(); tick();
    begin
      int ord [4] = '{2, 3, 4, 1};
      for (int k = 0; k < 4; k++) begin
        chk("R6 four-way order", 32'(od(0)), 32'(mk(0, 20+ord[k])));
        chk("R6 four-way valid", 32'(out_valid[0]), 1);
        tick();
      end
    end

    // R7: two circuits to south; input 1 wins, input 3 goes as packet
    cfg(1, 2, 1'b1);
    cfg(3, 2, 1'b1);
    put(1, 1'b1, mk(0, 5));
    put(3, 1'b1, mk(2, 6));
    tick(); idle();
    chk("R7 winner valid", 32'(out_valid), 1 << 2);
    chk("R7 winner tag", 32'(out_circ), 1 << 2);
    chk("R7 winner data", 32'(od(2)), 32'(mk(0, 5)));
    tick();
    chk("R7 gap", 32'(out_valid), 0);
    tick();
    chk("R7 loser valid", 32'(out_valid), 1 << 2);
    chk("R7 loser tag", 32'(out_circ), 0);
    chk("R7 loser data", 32'(od(2)), 32'(mk(2, 6)));
    cfg(1, 2, 1'b0);
    cfg(3, 2, 1'b0);

    // R8: block east with circuits, fill input 2, then drain in order
    cfg(0, 3, 1'b1);
    for (int k = 0; k < DEPTH; k++) begin
      put(0, 1'b1, mk(0, k));
      put(2, 1'b0, mk(3, 16+k));
      tick();
      chk("R8 circuit keeps link", 32'(out_circ[3]), 1);
    end
    in_valid[2] = 1'b0;
    put(0, 1'b1, mk(0, 7));
    tick();
    chk("R8 ready low when full", 32'(in_ready[2]), 0);
    chk("R8 circuit keeps link", 32'(out_circ[3]), 1);
    idle();
    begin
      int got = 0;
      for (int c = 0; c < 12; c++) begin
        tick();
        if (out_valid[3]) begin
          if (got < DEPTH) chk("R8 drain order", 32'(od(3)), 32'(mk(3, 16+got)));
          chk("R8 drain tag", 32'(out_circ[3]), 0);
          got++;
        end
      end
      chk("R8 drain count", 32'(got), DEPTH);
    end
    chk("R8 ready restored", 32'(in_ready[2]), 1);
    cfg(0, 3, 1'b0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule